// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the source and destination addresses for one DMA channel during a single block transfer. A load pulse captures the two start addresses, a 32-bit control word, the gather and scatter settings and the block size in elements. After that, each pulse on the advance strobe moves both addresses on by one element. Each side steps on its own: it can count up, count down or stay fixed, and it uses its own element width.

Either side can also skip ahead at a fixed interval. When gather is enabled on the source, or scatter on the destination, that address takes an extra jump after every programmed number of elements. The jump is the programmed interval multiplied by the element size, and it goes in the same direction as the address update.

Each side has its own burst-end flag. The flag marks the element that closes a burst or closes the block. A registered done flag rises once the programmed number of elements has been consumed. Bus timing, data movement, handshakes and descriptor chaining belong to neighbouring logic.

Top module: `dma_addr_seq`

## Requirements
- R1: While reset is held, and after it is released, both addresses read 0, `done` is 0 and both burst-end flags are 0.
- R2: A `load` pulse sets both addresses to their start values and restarts the element, burst and skip counters. After it, `done` reads 0 when `blk_size` is nonzero and 1 when `blk_size` is 0. `load` takes priority over `adv` in the same cycle.
- R3: Element width codes are taken from `ctl_lo[3:1]` for the destination and `ctl_lo[6:4]` for the source. Codes 0, 1 and 2 mean 1, 2 and 4 bytes per element. Codes 3 to 7 are treated as 4 bytes.
- R4: Update modes are taken from `ctl_lo[8:7]` for the destination and `ctl_lo[10:9]` for the source. Code 0 adds the element size on each accepted advance, code 1 subtracts it, and codes 2 and 3 leave the address unchanged. Arithmetic wraps modulo 2^32.
- R5: Source gather is enabled by `ctl_lo[17]`. `gath_cfg[19:0]` gives the interval and `gath_cfg[31:20]` gives the count. On every count-th accepted element, the source address moves by an extra interval times the element size, in the update direction. Gather has no effect when the source mode is fixed or the count is 0.
- R6: Destination scatter is enabled by `ctl_lo[18]` and configured through `scat_cfg`, which uses the same field layout as `gath_cfg`. It acts on the destination address under the same rules as R5.
- R7: Burst codes are taken from `ctl_lo[13:11]` for the destination and `ctl_lo[16:14]` for the source. Code 0 means a 1-element burst and code n ≥ 1 means 2^(n+1) elements. A side's burst-end flag is high while the block is running and the current element (0-based index k) satisfies k mod burst length = burst length − 1.
- R8: Both burst-end flags are also high while the current element is the last one in the block (k = `blk_size` − 1).
- R9: `done` rises in the cycle after the `blk_size`-th accepted advance. It stays high until the next `load`. While `done` is high, both burst-end flags are 0.
- R10: `adv` pulses before the first load, or after `done`, change neither address nor `done`.
- R11: While a block is running, a cycle with `adv` low leaves both addresses and all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a new block with the values on the inputs below |
| ctl_lo | input | 32 | Control word: widths, modes, burst codes, gather/scatter enables |
| blk_size | input | 12 | Block size in elements |
| src_start | input | 32 | Source start address |
| dst_start | input | 32 | Destination start address |
| gath_cfg | input | 32 | Source skip: interval [19:0], count [31:20] |
| scat_cfg | input | 32 | Destination skip: interval [19:0], count [31:20] |
| adv | input | 1 | One element consumed this cycle |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| src_burst_end | output | 1 | Current element closes a source burst or the block |
| dst_burst_end | output | 1 | Current element closes a destination burst or the block |
| done | output | 1 | Block complete |

## Verification
Every piece of internal state shows up at the ports quickly. A wrong skip counter shows as an address off by interval times width on the first skip element, which is at most `count` advances after load. A burst counter that has slipped moves the burst-end flag off its expected element within one burst length. An error in the element count shows as `done` rising one cycle early or late, together with a burst-end flag on the wrong element. The sweep compares both addresses and all three flags in every cycle of every block, so a fault is reported in the first cycle where it becomes visible.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    UPD_INC  = 2'd0,
    UPD_DEC  = 2'd1,
    UPD_HOLD = 2'd2,
    UPD_HLD3 = 2'd3
  } upd_mode_e;

  // log2 of bytes per element; codes above 2 saturate at 4 bytes
  function automatic logic [1:0] elem_shift(input logic [2:0] wcode);
    return (wcode >= 3'd2) ? 2'd2 : wcode[1:0];
  endfunction

  // elements per burst: 1 for code 0, else 2^(code+1)
  function automatic logic [8:0] burst_len(input logic [2:0] code);
    logic [3:0] e;
    e = 4'(code) + 4'd1;
    return (code == 3'd0) ? 9'd1 : (9'd1 << e);
  endfunction

endpackage

// File: rtl/dma_seq_blkctr.sv
module dma_seq_blkctr #(
  parameter int SZW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [SZW-1:0] size,
  input  logic           adv,
  output logic           busy,
  output logic           done,
  output logic           last_elem,
  output logic           step_en
);

  logic [SZW-1:0] cnt_q;
  logic [SZW-1:0] size_q;
  logic           busy_q;
  logic           done_q;

  assign busy      = busy_q;
  assign done      = done_q;
  assign step_en   = busy_q && adv && !load;
  assign last_elem = busy_q && (cnt_q == size_q - SZW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      size_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= '0;
      size_q <= size;
      busy_q <= (size != '0);
      done_q <= (size == '0);
    end else if (step_en) begin
      if (last_elem) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + SZW'(1);
      end
    end
  end

  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && last_elem |=> done && !busy);
  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && (size != '0) |=> !done && busy);
  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !load |=> $stable(done) && !busy);
  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: rtl/dma_seq_side.sv
module dma_seq_side
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IVW = 20,
  parameter int CNW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  start,
  input  logic [2:0]     wcode,
  input  logic [1:0]     mode,
  input  logic [2:0]     bcode,
  input  logic           sg_en,
  input  logic [IVW-1:0] sg_ivl,
  input  logic [CNW-1:0] sg_cnt,
  input  logic           active,
  input  logic           step_en,
  input  logic           last_elem,
  output logic [AW-1:0]  addr,
  output logic           burst_end
);

  logic [AW-1:0]  addr_q, addr_nxt;
  logic [1:0]     sh_q;
  upd_mode_e      mode_q;
  logic [8:0]     blen_q;
  logic [8:0]     bcnt_q;
  logic           sg_on_q;
  logic [IVW-1:0] ivl_q;
  logic [CNW-1:0] cnt_q;
  logic [CNW-1:0] gcnt_q;

  // named internal events
  logic skip_evt;
  logic burst_wrap;

  assign skip_evt   = sg_on_q && (gcnt_q == cnt_q - CNW'(1));
  assign burst_wrap = (bcnt_q == blen_q - 9'd1);
  assign burst_end  = active && (burst_wrap || last_elem);
  assign addr       = addr_q;

  function automatic logic [AW-1:0] step_delta(input logic [1:0] sh,
                                               input logic skip,
                                               input logic [IVW-1:0] ivl);
    logic [AW-1:0] d;
    d = AW'(1) << sh;
    if (skip) d = d + (AW'(ivl) << sh);
    return d;
  endfunction

  always_comb begin
    case (mode_q)
      UPD_INC: addr_nxt = addr_q + step_delta(sh_q, skip_evt, ivl_q);
      UPD_DEC: addr_nxt = addr_q - step_delta(sh_q, skip_evt, ivl_q);
      default: addr_nxt = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sh_q    <= '0;
      mode_q  <= UPD_INC;
      blen_q  <= 9'd1;
      bcnt_q  <= '0;
      sg_on_q <= 1'b0;
      ivl_q   <= '0;
      cnt_q   <= '0;
      gcnt_q  <= '0;
    end else if (load) begin
      addr_q  <= start;
      sh_q    <= elem_shift(wcode);
      mode_q  <= upd_mode_e'(mode);
      blen_q  <= burst_len(bcode);
      bcnt_q  <= '0;
      sg_on_q <= sg_en && !mode[1] && (sg_cnt != '0);
      ivl_q   <= sg_ivl;
      cnt_q   <= sg_cnt;
      gcnt_q  <= '0;
    end else if (step_en) begin
      addr_q <= addr_nxt;
      bcnt_q <= burst_wrap ? 9'd0 : bcnt_q + 9'd1;
      if (sg_on_q) gcnt_q <= skip_evt ? '0 : gcnt_q + CNW'(1);
    end
  end

  // R4
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && mode_q[1] && !load |=> $stable(addr));
  // R11
  no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en && !load |=> $stable(addr));
  // R7
  burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && burst_wrap && !load |=> bcnt_q == 9'd0);
  // R3
  plain_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (mode_q == UPD_INC) && !skip_evt && !load
    |=> addr == $past(addr) + (AW'(1) << $past(sh_q)));
  // R5
  skip_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |-> !mode_q[1]);

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 12,
  parameter int IVW = 20,
  parameter int CNW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [31:0]        ctl_lo,
  input  logic [SZW-1:0]     blk_size,
  input  logic [AW-1:0]      src_start,
  input  logic [AW-1:0]      dst_start,
  input  logic [IVW+CNW-1:0] gath_cfg,
  input  logic [IVW+CNW-1:0] scat_cfg,
  input  logic               adv,
  output logic [AW-1:0]      src_addr,
  output logic [AW-1:0]      dst_addr,
  output logic               src_burst_end,
  output logic               dst_burst_end,
  output logic               done
);

  localparam int NSIDE = 2;   // index 0 = source, 1 = destination

  logic busy, last_elem, step_en;

  logic [2:0]           wsel [NSIDE];
  logic [1:0]           msel [NSIDE];
  logic [2:0]           bsel [NSIDE];
  logic                 esel [NSIDE];
  logic [IVW+CNW-1:0]   csel [NSIDE];
  logic [AW-1:0]        ssel [NSIDE];
  logic [AW-1:0]        aout [NSIDE];
  logic                 beout[NSIDE];

  // control word field positions
  assign wsel[0] = ctl_lo[6:4];
  assign wsel[1] = ctl_lo[3:1];
  assign msel[0] = ctl_lo[10:9];
  assign msel[1] = ctl_lo[8:7];
  assign bsel[0] = ctl_lo[16:14];
  assign bsel[1] = ctl_lo[13:11];
  assign esel[0] = ctl_lo[17];
  assign esel[1] = ctl_lo[18];
  assign csel[0] = gath_cfg;
  assign csel[1] = scat_cfg;
  assign ssel[0] = src_start;
  assign ssel[1] = dst_start;

  logic unused_ctl;
  assign unused_ctl = ^{ctl_lo[31:19], ctl_lo[0]};

  dma_seq_blkctr #(.SZW(SZW)) u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .size      (blk_size),
    .adv       (adv),
    .busy      (busy),
    .done      (done),
    .last_elem (last_elem),
    .step_en   (step_en)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_seq_side #(.AW(AW), .IVW(IVW), .CNW(CNW)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .start     (ssel[s]),
      .wcode     (wsel[s]),
      .mode      (msel[s]),
      .bcode     (bsel[s]),
      .sg_en     (esel[s]),
      .sg_ivl    (csel[s][IVW-1:0]),
      .sg_cnt    (csel[s][IVW +: CNW]),
      .active    (busy),
      .step_en   (step_en),
      .last_elem (last_elem),
      .addr      (aout[s]),
      .burst_end (beout[s])
    );
  end

  assign src_addr      = aout[0];
  assign dst_addr      = aout[1];
  assign src_burst_end = beout[0];
  assign dst_burst_end = beout[1];

  // R8
  block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_elem |-> src_burst_end && dst_burst_end);
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !src_burst_end && !dst_burst_end);

endmodule

// File: tb/dma_addr_seq_bench.sv
module dma_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] ctl_lo = '0;
  logic [11:0] blk_size = '0;
  logic [31:0] src_start = '0, dst_start = '0;
  logic [31:0] gath_cfg = '0, scat_cfg = '0;
  logic        adv = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic        src_burst_end, dst_burst_end, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_addr_seq u_dma_addr_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .ctl_lo(ctl_lo),
    .blk_size(blk_size), .src_start(src_start), .dst_start(dst_start),
    .gath_cfg(gath_cfg), .scat_cfg(scat_cfg), .adv(adv),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .src_burst_end(src_burst_end), .dst_burst_end(dst_burst_end),
    .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bytes_of(input int w);
    return (w > 2) ? 4 : (1 << w);
  endfunction

  function automatic int blen_of(input int c);
    return (c == 0) ? 1 : (1 << (c + 1));
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] st, input int mode,
      input int bytes, input int k, input bit en, input int cnt, input int ivl);
    logic [31:0] d;
    if (mode >= 2) return st;
    d = 32'(k * bytes);
    if (en && cnt != 0) d = d + 32'((k / cnt) * ivl * bytes);
    return (mode == 0) ? st + d : st - d;
  endfunction

  task automatic run_block(input int ws, input int wd, input int ms, input int md,
      input int bs, input int bd, input bit gs, input bit sd,
      input int ivs, input int cs, input int ivd, input int cd,
      input int size, input logic [31:0] sa, input logic [31:0] da, input int gap_at);
    int bls, bld;
    logic [31:0] es, ed;
    bls = blen_of(bs);
    bld = blen_of(bd);
    @(negedge clk);
    ctl_lo = (32'(wd) << 1) | (32'(ws) << 4) | (32'(md) << 7) | (32'(ms) << 9) |
             (32'(bd) << 11) | (32'(bs) << 14) | (32'(gs) << 17) | (32'(sd) << 18);
    gath_cfg  = (32'(cs) << 20) | 32'(ivs);
    scat_cfg  = (32'(cd) << 20) | 32'(ivd);
    blk_size  = 12'(size);
    src_start = sa;
    dst_start = da;
    load = 1'b1;
    adv  = 1'b1;            // load wins over adv (R2)
    @(negedge clk);
    load = 1'b0;
    adv  = 1'b0;
    chk("R2 load src", src_addr, sa);
    chk("R2 load dst", dst_addr, da);
    chk("R2 load done", 32'(done), 32'(size == 0));
    for (int k = 0; k < size; k++) begin
      es = exp_addr(sa, ms, bytes_of(ws), k, gs, cs, ivs);
      ed = exp_addr(da, md, bytes_of(wd), k, sd, cd, ivd);
      chk("R3 R4 R5 src addr", src_addr, es);
      chk("R3 R4 R6 dst addr", dst_addr, ed);
      chk("R7 R8 src burst end", 32'(src_burst_end),
          32'(((k % bls) == bls - 1) || (k == size - 1)));
      chk("R7 R8 dst burst end", 32'(dst_burst_end),
          32'(((k % bld) == bld - 1) || (k == size - 1)));
      chk("R9 done low", 32'(done), 32'd0);
      if (k == gap_at) begin
        adv = 1'b0;
        @(negedge clk);
        chk("R11 gap src", src_addr, es);
        chk("R11 gap dst", dst_addr, ed);
        chk("R11 gap done", 32'(done), 32'd0);
      end
      adv = 1'b1;
      @(negedge clk);
    end
    adv = 1'b0;
    es = exp_addr(sa, ms, bytes_of(ws), size, gs, cs, ivs);
    ed = exp_addr(da, md, bytes_of(wd), size, sd, cd, ivd);
    chk("R3 R4 R5 final src", src_addr, es);
    chk("R3 R4 R6 final dst", dst_addr, ed);
    chk("R9 done high", 32'(done), 32'd1);
    chk("R9 burst ends quiet", 32'({src_burst_end, dst_burst_end}), 32'd0);
    adv = 1'b1;
    repeat (3) @(negedge clk);
    adv = 1'b0;
    chk("R10 after done src", src_addr, es);
    chk("R10 after done dst", dst_addr, ed);
    chk("R10 after done flag", 32'(done), 32'd1);
  endtask

  initial begin
    #20000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset src", src_addr, 32'd0);
    chk("R1 reset dst", dst_addr, 32'd0);
    chk("R1 reset flags", 32'({done, src_burst_end, dst_burst_end}), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset flags", 32'({done, src_burst_end, dst_burst_end}), 32'd0);
    adv = 1'b1;
    repeat (3) @(negedge clk);
    adv = 1'b0;
    chk("R10 pre-load src", src_addr, 32'd0);
    chk("R10 pre-load dst", dst_addr, 32'd0);
    chk("R10 pre-load done", 32'(done), 32'd0);

    for (int ws = 0; ws < 4; ws++) begin
      for (int ms = 0; ms < 4; ms++) begin
        run_block(ws, 3 - ws, ms, (ms + 2) % 4, ms, (ws + 1) % 4,
                  ((ws + ms) % 2) == 0, ws[0],
                  16 + ws, (ws == 3) ? 0 : 1 + ms, 3 + ms, 2 + ws,
                  3 + (ws * 4 + ms) % 11,
                  32'h1000_0000 + 32'(ws * 256), 32'h0000_0040,
                  (ms == 1) ? 1 : -1);
      end
    end
    // zero-size block
    run_block(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0,
              32'h100, 32'h200, -1);
    // single element, longest burst on one side
    run_block(2, 1, 1, 0, 7, 0, 1'b0, 1'b0, 0, 0, 0, 0, 1,
              32'h0, 32'hFFFF_FFFE, -1);
    // long block: longest burst, max interval gather, decrementing scatter wrapping below 0
    run_block(1, 2, 0, 1, 7, 2, 1'b1, 1'b1, 20'hFFFFF, 7, 5, 3, 300,
              32'h0000_1000, 32'h0000_0100, 150);
    // enables set while both sides are fixed
    run_block(2, 0, 2, 3, 1, 1, 1'b1, 1'b1, 9, 1, 9, 1, 6,
              32'hABCD_0000, 32'h1234_5678, -1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule